// File: doc/BRIEF.md
# Port Pin Drive and Input Filter

An eight-pin general-purpose port block that sits on a simple register bus. Four registers hold the output value, the direction, the per-pin drive mode (push-pull or open-drain) and the per-pin filter enable. From these the block drives a pad output-enable and a pad output value for every pin.

Every pad input goes through a two-flop synchronizer. Some pins can also be filtered. A filtered pin ignores a new level until that level has been seen on three debounce ticks in a row. The debounce tick is a strobe that comes from clock logic elsewhere on the chip. A stop-mode input switches all filtering off while it is high. When stop mode ends, each filter loads its held level from the live pin value, so no false edge appears. Software does not have to rewrite any register to bring filtering back.

Each filter is a small state machine with four states:

- FLT_OFF: the filter is bypassed because it is disabled or stop mode is high.
- FLT_HOLD: the held level matches the last sample.
- FLT_RUN1: one sample in a row has differed from the held level.
- FLT_RUN2: two samples in a row have differed from the held level.

The transitions are as follows:

- enter: FLT_OFF goes to FLT_HOLD once the filter is active.
- leave: any state goes to FLT_OFF when the filter stops being active.
- diverge: FLT_HOLD goes to FLT_RUN1 on a tick whose sample differs from the held level.
- persist: FLT_RUN1 goes to FLT_RUN2 on a tick whose sample still differs.
- accept: FLT_RUN2 goes to FLT_HOLD and loads the new level, on a tick whose sample still differs.
- break: FLT_RUN1 or FLT_RUN2 goes back to FLT_HOLD on a tick whose sample matches the held level.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: A write with `bus_wr` high stores `bus_wdata` in the register chosen by `bus_addr`. Address 0 is the output value, 1 is the direction (1 = output), 2 is the drive mode (1 = open-drain) and 3 is the filter enable. `bus_rdata` shows the register chosen by `bus_addr` in the same cycle.
- R2: After reset the drive-mode register reads 0x08, so only pin 3 is open-drain. The output value, direction and filter-enable registers read 0x00.
- R3: Filter-enable bits exist only at the positions set in `DB_MASK` (default 0xC6: pins 1, 2, 6 and 7). The other bits always read 0, and writes to them are ignored.
- R4: For a push-pull pin, `pad_oe` equals its direction bit and `pad_out` equals its output-value bit.
- R5: For an open-drain pin, `pad_out` is 0 and `pad_oe` is high only when its direction bit is 1 and its output-value bit is 0.
- R6: A change on `pin_in` reaches `pin_filt` on the second rising clock edge when the pin is not filtered.
- R7: On an active filtered pin, `pin_filt` takes a new level only on the third consecutive `dbnc_tick` at which the synchronized input differs from the held level.
- R8: On an active filtered pin, an input excursion that spans fewer than three ticks never appears on `pin_filt`.
- R9: While `stop_mode` is high, `pin_filt` equals the synchronized input on every pin.
- R10: After `stop_mode` falls, filtering comes back with no register write. The held level starts at the synchronized input, so no edge is produced by the release itself.
- R11: Clearing a pin's filter-enable bit makes `pin_filt` follow the synchronized input in the cycle right after the write.
- R12: Pins with no filter, or with their filter disabled, pass the synchronized input to `pin_filt` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| dbnc_tick | input | 1 | One-cycle debounce sampling strobe |
| stop_mode | input | 1 | Stop-mode indicator; bypasses all filters |
| pin_in | input | 8 | Raw pad input levels |
| pad_oe | output | 8 | Pad output enable per pin |
| pad_out | output | 8 | Pad output level per pin |
| pin_filt | output | 8 | Synchronized, optionally filtered pin levels |

## Verification
The bench goes after runs of exactly two and exactly three ticks. A filter that miscounts would either let a two-tick glitch through or add a tick of delay to a real edge. It also checks that a run broken by a matching sample starts counting again from zero. A design that kept the partial count would accept an edge too early.

Entry to and exit from stop mode are checked against the live pin. A design that did not preload the held level on release would show a false edge. A design that kept filtering during stop mode would hide the pin.

Writes of all ones to the filter enable check that bits without a filter stay 0. The drive-mode patterns catch an open-drain pin that drives a high level.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;

    // Per-pin filter states
    typedef enum logic [1:0] {
        FLT_OFF  = 2'd0,
        FLT_HOLD = 2'd1,
        FLT_RUN1 = 2'd2,
        FLT_RUN2 = 2'd3
    } flt_state_t;

    // Register select encoding on the bus address
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_MODE = 2'd2,
        SEL_DBEN = 2'd3
    } reg_sel_t;

endpackage

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs
    import gpio_pin_pkg::*;
#(
    parameter int unsigned     W        = 8,
    parameter logic [W-1:0]    MODE_RST = 8'h08,
    parameter logic [W-1:0]    DB_MASK  = 8'hC6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic [W-1:0] data_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] mode_q,
    output logic [W-1:0] dben_q
);

    reg_sel_t sel;

    assign sel = reg_sel_t'(addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            mode_q <= MODE_RST;
            dben_q <= '0;
        end else if (wr) begin
            unique case (sel)
                SEL_DATA: data_q <= wdata;
                SEL_DIR:  dir_q  <= wdata;
                SEL_MODE: mode_q <= wdata;
                SEL_DBEN: dben_q <= wdata & DB_MASK;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_DATA: rdata = data_q;
            SEL_DIR:  rdata = dir_q;
            SEL_MODE: rdata = mode_q;
            SEL_DBEN: rdata = dben_q;
        endcase
    end

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    localparam int unsigned LAST = STAGES - 1;

    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain[0] <= '0;
        end else begin
            chain[0] <= d;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[s] <= '0;
            end else begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[LAST];

endmodule

// File: rtl/gpio_pin_filter.sv
module gpio_pin_filter
    import gpio_pin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic active,
    input  logic raw,
    output logic filt
);

    flt_state_t state, nxt;
    logic       held;
    logic       differs;

    assign differs = (raw != held);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FLT_OFF;
        end else begin
            state <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            FLT_OFF: begin
                if (active) nxt = FLT_HOLD;                      // enter
            end
            FLT_HOLD: begin
                if (!active)                nxt = FLT_OFF;       // leave
                else if (tick && differs)   nxt = FLT_RUN1;      // diverge
            end
            FLT_RUN1: begin
                if (!active)                nxt = FLT_OFF;       // leave
                else if (tick && differs)   nxt = FLT_RUN2;      // persist
                else if (tick)              nxt = FLT_HOLD;      // break
            end
            FLT_RUN2: begin
                if (!active)                nxt = FLT_OFF;       // leave
                else if (tick)              nxt = FLT_HOLD;      // accept or break
            end
        endcase
    end

    // Held level: follows raw while bypassed, loads on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= 1'b0;
        end else if (!active || state == FLT_OFF) begin
            held <= raw;
        end else if (state == FLT_RUN2 && tick && differs) begin
            held <= raw;
        end
    end

    // Output process
    always_comb begin
        filt = raw;
        unique case (state)
            FLT_OFF:  filt = raw;
            FLT_HOLD,
            FLT_RUN1,
            FLT_RUN2: filt = active ? held : raw;
        endcase
    end

endmodule

// File: rtl/gpio_pin_pad.sv
module gpio_pin_pad #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] data_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] mode_q,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        always_comb begin
            if (mode_q[i]) begin
                // open-drain: pull low only, release for a one
                pad_oe[i]  = dir_q[i] & ~data_q[i];
                pad_out[i] = 1'b0;
            end else begin
                pad_oe[i]  = dir_q[i];
                pad_out[i] = data_q[i];
            end
        end
    end

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl #(
    parameter int unsigned  W        = 8,
    parameter int unsigned  SYNC_LEN = 2,
    parameter logic [W-1:0] MODE_RST = 8'h08,
    parameter logic [W-1:0] DB_MASK  = 8'hC6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic [1:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic         dbnc_tick,
    input  logic         stop_mode,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pin_filt
);

    logic [W-1:0] data_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] mode_q;
    logic [W-1:0] dben_q;
    logic [W-1:0] raw_sync;

    gpio_pin_regs #(
        .W        (W),
        .MODE_RST (MODE_RST),
        .DB_MASK  (DB_MASK)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .data_q (data_q),
        .dir_q  (dir_q),
        .mode_q (mode_q),
        .dben_q (dben_q)
    );

    gpio_pin_pad #(
        .W (W)
    ) u_pad (
        .data_q  (data_q),
        .dir_q   (dir_q),
        .mode_q  (mode_q),
        .pad_oe  (pad_oe),
        .pad_out (pad_out)
    );

    gpio_pin_sync #(
        .W      (W),
        .STAGES (SYNC_LEN)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (raw_sync)
    );

    for (genvar i = 0; i < W; i++) begin : g_flt
        if (DB_MASK[i]) begin : g_on
            gpio_pin_filter u_filter (
                .clk    (clk),
                .rst_n  (rst_n),
                .tick   (dbnc_tick),
                .active (dben_q[i] & ~stop_mode),
                .raw    (raw_sync[i]),
                .filt   (pin_filt[i])
            );
        end else begin : g_off
            assign pin_filt[i] = raw_sync[i];
        end
    end

endmodule

// File: rtl/gpio_pin_chk.sv
module gpio_pin_chk #(
    parameter int unsigned  W        = 8,
    parameter logic [W-1:0] MODE_RST = 8'h08,
    parameter logic [W-1:0] DB_MASK  = 8'hC6
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         stop,
    input logic [W-1:0] dben,
    input logic [W-1:0] mode,
    input logic [W-1:0] raw,
    input logic [W-1:0] filt,
    input logic [W-1:0] oe,
    input logic [W-1:0] out
);

    logic [W-1:0] live;

    assign live = dben & ~{W{stop}};

    AST_DBEN_UNSUPPORTED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dben & ~DB_MASK) == '0); // R3

    AST_MODE_RESET_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mode == MODE_RST)); // R2

    AST_OPEN_DRAIN_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode & oe & out) == '0); // R5

    AST_STOP_PASSTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        stop |-> (filt == raw)); // R9

    AST_FILTER_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (((filt ^ $past(filt)) & live & $past(live)) != '0) |-> $past(tick)); // R7

endmodule

bind gpio_pin_ctrl gpio_pin_chk #(
    .W        (W),
    .MODE_RST (MODE_RST),
    .DB_MASK  (DB_MASK)
) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (dbnc_tick),
    .stop (stop_mode),
    .dben (dben_q),
    .mode (mode_q),
    .raw  (raw_sync),
    .filt (pin_filt),
    .oe   (pad_oe),
    .out  (pad_out)
);

// File: tb/gpio_pin_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_pin_ctrl_tb;

    localparam time        CLK_P = 20ns;
    localparam logic [7:0] MASK  = 8'hC6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       dbnc_tick = 1'b0;
    logic       stop_mode = 1'b0;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pad_oe;
    logic [7:0] pad_out;
    logic [7:0] pin_filt;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  mon_on = 1'b0;
    bit  done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    gpio_pin_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .dbnc_tick (dbnc_tick),
        .stop_mode (stop_mode),
        .pin_in    (pin_in),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out),
        .pin_filt  (pin_filt)
    );

    // ---------------- behavioural reference ----------------
    logic [7:0] m_data, m_dir, m_mode, m_dben, m_s1, m_s2, m_acc, m_on;
    int         m_cnt [8];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_data <= 8'h00; m_dir <= 8'h00; m_mode <= 8'h08; m_dben <= 8'h00;
            m_s1 <= 8'h00; m_s2 <= 8'h00; m_acc <= 8'h00; m_on <= 8'h00;
            for (int i = 0; i < 8; i++) m_cnt[i] <= 0;
        end else begin
            if (bus_wr) begin
                case (bus_addr)
                    2'd0: m_data <= bus_wdata;
                    2'd1: m_dir  <= bus_wdata;
                    2'd2: m_mode <= bus_wdata;
                    default: m_dben <= bus_wdata & MASK;
                endcase
            end
            m_s1 <= pin_in;
            m_s2 <= m_s1;
            for (int i = 0; i < 8; i++) begin
                if (MASK[i]) begin
                    if (!(m_dben[i] && !stop_mode)) begin
                        m_on[i] <= 1'b0; m_acc[i] <= m_s2[i]; m_cnt[i] <= 0;
                    end else if (!m_on[i]) begin
                        m_on[i] <= 1'b1; m_acc[i] <= m_s2[i]; m_cnt[i] <= 0;
                    end else if (dbnc_tick) begin
                        if (m_s2[i] != m_acc[i]) begin
                            if (m_cnt[i] == 2) begin
                                m_acc[i] <= m_s2[i]; m_cnt[i] <= 0;
                            end else begin
                                m_cnt[i] <= m_cnt[i] + 1;
                            end
                        end else begin
                            m_cnt[i] <= 0;
                        end
                    end
                end
            end
        end
    end

    function automatic logic [7:0] exp_filt();
        logic [7:0] r;
        for (int i = 0; i < 8; i++)
            r[i] = (MASK[i] && m_dben[i] && !stop_mode && m_on[i]) ? m_acc[i] : m_s2[i];
        return r;
    endfunction

    function automatic logic [7:0] exp_rdata();
        case (bus_addr)
            2'd0: return m_data;
            2'd1: return m_dir;
            2'd2: return m_mode;
            default: return m_dben;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference, away from the clock edge
    always @(negedge clk) begin
        #5;
        if (mon_on && rst_n) begin
            check("R1 rdata", bus_rdata, exp_rdata());
            check("R4/R5 pad_oe", pad_oe, (m_dir & ~m_mode) | (m_dir & m_mode & ~m_data));
            check("R4/R5 pad_out", pad_out, m_data & ~m_mode);
            check("R7/R12 pin_filt", pin_filt, exp_filt());
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk); dbnc_tick = 1'b1;
        @(negedge clk); dbnc_tick = 1'b0;
        cyc(1);
    endtask

    task automatic look(input logic [1:0] a);
        @(negedge clk); bus_addr = a; #5;
    endtask

    task automatic settle();
        @(negedge clk); #5;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        cyc(3);
        @(negedge clk) rst_n = 1'b1;
        mon_on = 1'b1;

        // R2: reset values
        look(2'd0); check("R2 data reset", bus_rdata, 8'h00);
        look(2'd1); check("R2 dir reset", bus_rdata, 8'h00);
        look(2'd2); check("R2 mode reset", bus_rdata, 8'h08);
        look(2'd3); check("R2 dben reset", bus_rdata, 8'h00);

        // R1: write and read back
        wr(2'd0, 8'hA5); look(2'd0); check("R1 data readback", bus_rdata, 8'hA5);

        // R3: unsupported filter bits stay zero
        wr(2'd3, 8'hFF); look(2'd3); check("R3 dben masked", bus_rdata, 8'hC6);

        // R6 / R12: unfiltered pin 0 appears after two edges
        @(negedge clk) pin_in[0] = 1'b1;
        settle(); check("R6 one edge", {7'd0, pin_filt[0]}, 8'h00);
        settle(); check("R6 two edges", {7'd0, pin_filt[0]}, 8'h01);

        // R7: filtered pin 1 needs three ticks
        @(negedge clk) pin_in[1] = 1'b1;
        cyc(3); #5; check("R7 no tick", {7'd0, pin_filt[1]}, 8'h00);
        pulse_tick(); pulse_tick(); #5;
        check("R7 two ticks", {7'd0, pin_filt[1]}, 8'h00);
        pulse_tick(); #5;
        check("R7 third tick", {7'd0, pin_filt[1]}, 8'h01);

        // R8: a two-tick excursion is dropped
        @(negedge clk) pin_in[1] = 1'b0;
        cyc(3); pulse_tick(); pulse_tick();
        @(negedge clk) pin_in[1] = 1'b1;
        cyc(3); pulse_tick(); pulse_tick(); pulse_tick(); #5;
        check("R8 glitch dropped", {7'd0, pin_filt[1]}, 8'h01);

        // R7: broken run restarts the count
        @(negedge clk) pin_in[1] = 1'b0;
        cyc(3); pulse_tick(); pulse_tick();
        @(negedge clk) pin_in[1] = 1'b1;
        cyc(3); pulse_tick();
        @(negedge clk) pin_in[1] = 1'b0;
        cyc(3); pulse_tick(); #5;
        check("R7 restart after break", {7'd0, pin_filt[1]}, 8'h01);
        pulse_tick(); pulse_tick(); #5;
        check("R7 full run after break", {7'd0, pin_filt[1]}, 8'h00);

        // R9: stop mode passes raw input straight through
        @(negedge clk) pin_in[1] = 1'b1;
        cyc(3); pulse_tick(); pulse_tick(); pulse_tick();
        @(negedge clk) begin stop_mode = 1'b1; pin_in[1] = 1'b0; end
        cyc(3); #5; check("R9 stop bypass", {7'd0, pin_filt[1]}, 8'h00);

        // R10: release preloads the held level and filtering resumes
        @(negedge clk) stop_mode = 1'b0;
        #5; check("R10 release no edge", {7'd0, pin_filt[1]}, 8'h00);
        settle(); check("R10 release settled", {7'd0, pin_filt[1]}, 8'h00);
        @(negedge clk) pin_in[1] = 1'b1;
        cyc(3); pulse_tick(); pulse_tick(); #5;
        check("R10 filter resumed", {7'd0, pin_filt[1]}, 8'h00);
        pulse_tick(); #5;
        check("R10 filter accepts", {7'd0, pin_filt[1]}, 8'h01);

        // R11: disabling the filter exposes raw input at once
        @(negedge clk) pin_in[1] = 1'b0;
        cyc(3); #5; check("R11 before disable", {7'd0, pin_filt[1]}, 8'h01);
        wr(2'd3, 8'h00); #5;
        check("R11 after disable", {7'd0, pin_filt[1]}, 8'h00);

        // R4 / R5: drive modes
        wr(2'd1, 8'hFF); #5;
        check("R5 pin3 open-drain out", pad_out & 8'h08, 8'h00);
        check("R4 push-pull out", pad_out & 8'hF7, 8'hA5 & 8'hF7);
        wr(2'd2, 8'hF0); #5;
        check("R5 oe open-drain", pad_oe, 8'h5F);
        check("R5 out open-drain", pad_out, 8'h05);
        wr(2'd1, 8'h0F); #5;
        check("R4 oe follows dir", pad_oe, 8'h0F);

        // randomized phase, compared each cycle against the reference
        wr(2'd3, 8'hFF);
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            bus_addr  = 2'($urandom_range(0, 3));
            bus_wr    = ($urandom_range(0, 31) == 0);
            bus_wdata = 8'($urandom);
            dbnc_tick = ($urandom_range(0, 2) == 0);
            if ($urandom_range(0, 5) == 0) pin_in[$urandom_range(0, 7)] ^= 1'b1;
            if ($urandom_range(0, 99) == 0) stop_mode = ~stop_mode;
        end
        @(negedge clk) begin bus_wr = 1'b0; dbnc_tick = 1'b0; stop_mode = 1'b0; end
        cyc(4);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule